// File: doc/BRIEF.md
# DMX512 Frame Transmitter

This block sends lighting-control packets on a single serial line, over and over, for as long as it is enabled. Each packet has four parts. The line is first held low as a break, then held high as a mark-after-break. A start byte follows, and after it a full universe of slot bytes read from an internal slot memory. Every byte is sent as an asynchronous frame: one start bit, eight data bits with the LSB first, no parity and two stop bits. During break and mark-after-break the serializer sits idle and the sequencer forces the line level itself. From the start byte onward the serializer owns the line.

Break and mark-after-break are measured in periods of an external timing strobe, `tick_i`, which is nominally one pulse every 8 µs. The bit period is a parameter, `BIT_DIV`, given in clock cycles; for 250 kbaud it is 4 µs of the core clock. Software-side logic fills the slot memory through a valid/ready write port. `wr_ready_o` is always high, so the port never applies back-pressure: a write is taken on every cycle in which `wr_valid_i` is high. A write can land at any time, including while a packet is going out.

Top module: `dmx_tx`

## Requirements
- R1: After reset, and at any time the sequencer is idle, `tx_o` is high. `wr_ready_o` is high in every cycle.
- R2: Break: `tx_o` is low for exactly `BRK_TICKS` (default 22) clock edges on which `tick_i` is high. The last such edge ends the break. If ticks arrive every T cycles, the low time L satisfies (BRK_TICKS-1)*T < L <= BRK_TICKS*T.
- R3: Mark-after-break: `tx_o` is high for `MAB_TICKS` (default 2) tick edges, plus one further clock cycle, before the start bit of the start byte. If ticks arrive every T cycles, the high time H lies in [(MAB_TICKS-1)*T+2, MAB_TICKS*T+1].
- R4: Byte framing: the line carries a low start bit, then data bits 0 through 7, then two high stop bits. Each bit lasts exactly `BIT_DIV` cycles.
- R5: The first byte after mark-after-break is the value of `start_code_i` at the moment that byte is loaded. It is never taken from slot memory.
- R6: After the start byte, slots 0 through `NUM_SLOTS-1` are sent in ascending address order. A new break follows, so exactly `NUM_SLOTS+1` bytes lie between two breaks of a packet that is not interrupted.
- R7: After reset every slot reads 0x00.
- R8: A write is accepted on every cycle with `wr_valid_i` high. A write to a slot that has not yet been sent in the current packet appears in that same packet.
- R9: When `en_i` falls during a byte, that byte completes. No further frame starts and `tx_o` stays high. When `en_i` rises again, transmission restarts with a break.
- R10: Within a packet, consecutive bytes are back to back: each start bit begins exactly 11*`BIT_DIV` cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run control; high keeps packets repeating |
| tick_i | input | 1 | One-cycle timing strobe for break and mark-after-break |
| start_code_i | input | 8 | Value of the byte sent before the slots |
| wr_valid_i | input | 1 | Slot write request |
| wr_ready_o | output | 1 | Slot write accepted (always high) |
| wr_addr_i | input | $clog2(NUM_SLOTS) | Slot address to write |
| wr_data_i | input | 8 | Slot value to write |
| tx_o | output | 1 | Serial line output |

## Verification
Two situations are hard to reach from the ports. One is a slot write that lands after the packet has started but before that slot is read. The bench writes slot 300 once about twenty bytes of the first packet have been decoded, and it has already queued that new value as the expected slot 300 byte. The other is disabling partway through a byte, rather than between bytes. The bench watches the monitor's bit position and drops `en_i` in the middle of a frame of the second packet. It then confirms that the frame completes, that the line stays quiet, and that the first event after re-enabling is a break.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BRK  = 2'd1,
    ST_MAB  = 2'd2,
    ST_DATA = 2'd3
  } dmx_state_e;

  typedef logic [7:0] dmx_byte_t;

  // start + 8 data + 2 stop
  localparam int unsigned FRAME_BITS = 11;
endpackage

// File: rtl/dmx_slot_mem.sv
`timescale 1ns/1ps
module dmx_slot_mem
  import dmx_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  dmx_byte_t     wdata_i,
  input  logic [AW-1:0] raddr_i,
  output dmx_byte_t     rdata_o
);
  dmx_byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // Unregistered read: the sequencer sees a write on the next cycle.
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmx_uart_ser.sv
`timescale 1ns/1ps
module dmx_uart_ser
  import dmx_pkg::*;
#(
  parameter int unsigned BIT_DIV = 800,
  localparam int unsigned DW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  dmx_byte_t data_i,
  output logic      rdy_o,
  output logic      busy_o,
  output logic      line_o
);
  logic [DW-1:0]         div_q;
  logic [3:0]            bits_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  busy_q;
  logic                  bit_end;
  logic                  last_bit;

  assign bit_end  = busy_q && (div_q == DW'(BIT_DIV - 1));
  assign last_bit = bit_end && (bits_q == 4'd1);
  // A new byte may be taken on the edge that ends the last stop bit.
  assign rdy_o    = !busy_q || last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bits_q <= '0;
      sh_q   <= '1;
      busy_q <= 1'b0;
    end else if (load_i && rdy_o) begin
      sh_q   <= {2'b11, data_i, 1'b0};
      bits_q <= 4'(FRAME_BITS);
      div_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (bit_end) begin
        div_q  <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
        bits_q <= bits_q - 4'd1;
        if (bits_q == 4'd1) busy_q <= 1'b0;
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/dmx_seq.sv
`timescale 1ns/1ps
module dmx_seq
  import dmx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 512,
  parameter int unsigned BRK_TICKS = 22,
  parameter int unsigned MAB_TICKS = 2,
  localparam int unsigned AW = $clog2(NUM_SLOTS),
  localparam int unsigned PW = $clog2(NUM_SLOTS + 2),
  localparam int unsigned MAXT = (BRK_TICKS > MAB_TICKS) ? BRK_TICKS : MAB_TICKS,
  localparam int unsigned TW = $clog2(MAXT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  dmx_byte_t     start_code_i,
  input  logic          ser_rdy_i,
  input  logic          ser_busy_i,
  input  dmx_byte_t     rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          ser_load_o,
  output dmx_byte_t     ser_data_o,
  output dmx_state_e    state_o
);
  dmx_state_e    state_q;
  logic [TW-1:0] cnt_q;
  logic [PW-1:0] pos_q;   // 0 = start byte, k = slot k-1
  logic          all_sent;

  assign all_sent   = (pos_q == PW'(NUM_SLOTS + 1));
  assign rd_addr_o  = AW'(pos_q - PW'(1));
  assign ser_data_o = (pos_q == '0) ? start_code_i : rd_data_i;
  assign ser_load_o = (state_q == ST_DATA) && en_i && !all_sent && ser_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pos_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (en_i) begin
            state_q <= ST_BRK;
            cnt_q   <= '0;
          end
        end
        ST_BRK: begin
          if (!en_i) begin
            state_q <= ST_IDLE;
          end else if (tick_i) begin
            if (cnt_q == TW'(BRK_TICKS - 1)) begin
              state_q <= ST_MAB;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + TW'(1);
            end
          end
        end
        ST_MAB: begin
          if (!en_i) begin
            state_q <= ST_IDLE;
          end else if (tick_i) begin
            if (cnt_q == TW'(MAB_TICKS - 1)) begin
              state_q <= ST_DATA;
              cnt_q   <= '0;
              pos_q   <= '0;
            end else begin
              cnt_q <= cnt_q + TW'(1);
            end
          end
        end
        ST_DATA: begin
          if (ser_load_o) begin
            pos_q <= pos_q + PW'(1);
          end else if ((!en_i || all_sent) && !ser_busy_i) begin
            state_q <= en_i ? ST_BRK : ST_IDLE;
            cnt_q   <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dmx_tx.sv
`timescale 1ns/1ps
module dmx_tx
  import dmx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 512,
  parameter int unsigned BIT_DIV   = 800,
  parameter int unsigned BRK_TICKS = 22,
  parameter int unsigned MAB_TICKS = 2,
  localparam int unsigned AW = $clog2(NUM_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [7:0]    start_code_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  output logic          tx_o
);
  logic          ser_rdy;
  logic          ser_busy;
  logic          ser_line;
  logic          ser_load;
  dmx_byte_t     ser_data;
  dmx_byte_t     rd_data;
  logic [AW-1:0] rd_addr;
  dmx_state_e    seq_state;

  assign wr_ready_o = 1'b1;

  dmx_slot_mem #(.DEPTH(NUM_SLOTS)) mem_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_valid_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  dmx_seq #(
    .NUM_SLOTS (NUM_SLOTS),
    .BRK_TICKS (BRK_TICKS),
    .MAB_TICKS (MAB_TICKS)
  ) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .tick_i       (tick_i),
    .start_code_i (start_code_i),
    .ser_rdy_i    (ser_rdy),
    .ser_busy_i   (ser_busy),
    .rd_data_i    (rd_data),
    .rd_addr_o    (rd_addr),
    .ser_load_o   (ser_load),
    .ser_data_o   (ser_data),
    .state_o      (seq_state)
  );

  dmx_uart_ser #(.BIT_DIV(BIT_DIV)) ser_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ser_load),
    .data_i (ser_data),
    .rdy_o  (ser_rdy),
    .busy_o (ser_busy),
    .line_o (ser_line)
  );

  // Sequencer forces the level during break and mark-after-break.
  always_comb begin
    unique case (seq_state)
      ST_BRK:  tx_o = 1'b0;
      ST_MAB:  tx_o = 1'b1;
      default: tx_o = ser_line;
    endcase
  end
endmodule

// File: rtl/dmx_tx_chk.sv
`timescale 1ns/1ps
module dmx_tx_chk
  import dmx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       tick_i,
  input logic       tx_i,
  input dmx_state_e state_i,
  input logic       ser_busy_i,
  input logic       ser_load_i
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> tx_i);

  a_r2_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BRK) |-> !tx_i);

  a_r2_break_waits_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BRK && en_i && !tick_i) |=> (state_i == ST_BRK));

  a_r3_mab_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MAB) |-> tx_i);

  a_r4_start_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_busy_i) |-> (!tx_i && state_i == ST_DATA));

  a_r9_load_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_load_i |-> en_i);
endmodule

bind dmx_tx dmx_tx_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tick_i     (tick_i),
  .tx_i       (tx_o),
  .state_i    (seq_state),
  .ser_busy_i (ser_busy),
  .ser_load_i (ser_load)
);

// File: tb/dmx_tx_tb_top.sv
`timescale 1ns/1ps
module dmx_tx_tb_top;
  localparam int NSLOT = 512;
  localparam int DIV   = 4;
  localparam int TPER  = 8;
  localparam int BRK   = 22;
  localparam int MAB   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] start_code = 8'h00;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tx;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] model [NSLOT];
  logic [7:0] exp_q [$];

  int  frames_total = 0;
  int  frames_since = 0;
  int  breaks_seen = 0;
  bit  in_frame = 0;
  int  bit_idx = -1;
  bit  partial_ok = 0;

  dmx_tx #(.NUM_SLOTS(NSLOT), .BIT_DIV(DIV), .BRK_TICKS(BRK), .MAB_TICKS(MAB)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .tick_i       (tick),
    .start_code_i (start_code),
    .wr_valid_i   (wr_valid),
    .wr_ready_o   (wr_ready),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .tx_o         (tx)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic slot_write(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 9'(a); wr_data = d;
    check(wr_ready === 1'b1, "R8 write ready", int'(wr_ready), 1);
    @(negedge clk);
    wr_valid = 1'b0;
    model[a] = d;
  endtask

  // Driver side of the scoreboard: one full expected packet.
  task automatic push_packet(input logic [7:0] sc);
    exp_q.push_back(sc);
    for (int i = 0; i < NSLOT; i++) exp_q.push_back(model[i]);
  endtask

  // Periodic timing strobe.
  initial begin
    forever begin
      @(negedge clk);
      tick = (cyc % TPER == 3);
    end
  end

  // Monitor: decodes frames and breaks, compares against the queue.
  initial begin : mon
    bit have_fall = 0;
    int t0, t1, last_fall;
    logic [7:0] b;
    logic s1, s2;
    last_fall = -1;
    wait (rst_n === 1'b1);
    @(negedge clk);
    forever begin
      if (!have_fall) while (tx !== 1'b0) @(negedge clk);
      have_fall = 0;
      t0 = cyc;
      in_frame = 1;
      repeat (DIV/2) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        repeat (DIV) @(negedge clk);
        b[k] = tx;
        bit_idx = k;
      end
      repeat (DIV) @(negedge clk); s1 = tx;
      repeat (DIV) @(negedge clk); s2 = tx;
      in_frame = 0; bit_idx = -1;
      if (!s1 && b == 8'h00) begin
        // break
        while (tx !== 1'b1) @(negedge clk);
        t1 = cyc;
        check((t1 - t0) > (BRK-1)*TPER && (t1 - t0) <= BRK*TPER, "R2 break length",
              t1 - t0, BRK*TPER);
        while (tx !== 1'b0) @(negedge clk);
        check((cyc - t1) >= (MAB-1)*TPER + 2 && (cyc - t1) <= MAB*TPER + 1,
              "R3 mark-after-break length", cyc - t1, MAB*TPER + 1);
        if (breaks_seen > 0 && !partial_ok)
          check(frames_since == NSLOT + 1, "R6 bytes per packet", frames_since, NSLOT + 1);
        partial_ok = 0;
        breaks_seen++;
        frames_since = 0;
        last_fall = -1;
        have_fall = 1;
      end else begin
        check(s1 === 1'b1 && s2 === 1'b1, "R4 stop bits", int'({s1, s2}), 3);
        if (frames_since > 0 && last_fall >= 0)
          check(t0 - last_fall == 11*DIV, "R10 back-to-back spacing", t0 - last_fall, 11*DIV);
        last_fall = t0;
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected frame", int'(b), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (frames_since == 0)
            check(b === e, "R5 start byte", int'(b), int'(e));
          else
            check(b === e, "R6/R7/R8 slot byte", int'(b), int'(e));
        end
        frames_since++;
        frames_total++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin : main
    int c, brk_before;
    bit quiet;
    for (int i = 0; i < NSLOT; i++) model[i] = 8'h00;

    repeat (3) @(negedge clk);
    check(tx === 1'b1, "R1 line high in reset", int'(tx), 1);
    rst_n = 1'b1;
    quiet = 1;
    repeat (20) begin
      @(negedge clk);
      if (tx !== 1'b1 || wr_ready !== 1'b1) quiet = 0;
    end
    check(quiet, "R1 idle after reset", int'(quiet), 1);

    slot_write(0, 8'h11);
    slot_write(1, 8'hA5);
    slot_write(2, 8'h80);
    slot_write(255, 8'h3C);
    slot_write(511, 8'hFF);
    start_code = 8'hCC;
    model[300] = 8'h5A;     // written mid-packet below (R8)
    push_packet(8'hCC);     // other slots stay at reset value 0 (R7)
    en = 1'b1;

    wait (frames_total >= 20);
    slot_write(300, 8'h5A);
    start_code = 8'h17;
    push_packet(8'h17);

    wait (breaks_seen == 2 && frames_since >= 30);
    wait (in_frame && bit_idx == 3);
    en = 1'b0;
    c = frames_total;
    wait (!in_frame);
    @(negedge clk);
    quiet = 1;
    repeat (600) begin
      @(negedge clk);
      if (tx !== 1'b1) quiet = 0;
    end
    check(frames_total == c + 1, "R9 current byte completes", frames_total, c + 1);
    check(quiet, "R9 line idle after disable", int'(quiet), 1);

    exp_q.delete();
    partial_ok = 1;
    push_packet(8'h17);
    brk_before = breaks_seen;
    en = 1'b1;
    wait (frames_total > c + 1);
    check(breaks_seen == brk_before + 1, "R9 restart begins with break",
          breaks_seen, brk_before + 1);
    wait (frames_total > c + 8);
    repeat (50) @(negedge clk);
    finish_up();
  end
endmodule